// File: doc/BRIEF.md
# Transmit Character Capture and Odd-Parity Check

This block sits at the front of a serial transmit path. On every rising clock edge it takes in one character's worth of parallel inputs: eight data bits, two control bits, a special-character select bit and an odd-parity bit. It holds them in a register and presents them in the form that the next stage expects. When the encoder that follows is bypassed, the ten data and control bits leave as one pre-encoded 10-bit word. When the encoder is in use, data, control and the select bit leave on separate fields.

The same register stage also checks parity. It counts the ones across a set of covered inputs plus the parity bit, and the covered set depends on a three-level parity control and on whether the encoder is enabled. The error flag is registered, so it appears in the same cycle as the character that caused it.

Three-level configuration inputs are carried as 2-bit codes: 00 is LOW, 01 is MID, and 10 or 11 is HIGH.

Top module: `tx_char_capture`

## Requirements
- R1: Every output reflects the inputs sampled at the previous rising clock edge, which is one cycle of latency with no combinational path from input to output.
- R2: The encoder is taken as enabled when `xmode_enc` is not LOW (code 00). `enc_active` is 1 exactly when the captured `xmode_enc` was MID (01) or HIGH (10/11).
- R3: With the encoder bypassed, `raw_char[7:0]` carries data bits 0..7 in order, `raw_char[8]` carries `ctrl_in[0]` and `raw_char[9]` carries `ctrl_in[1]`. `enc_data`, `enc_ctrl` and `enc_sel` are 0.
- R4: With the encoder enabled, `enc_data` equals the captured data and `enc_ctrl` equals the captured control bits, and `raw_char` is 0.
- R5: `enc_sel` carries the captured `sel_in` only when the encoder is enabled and `xmode_sel` is not HIGH (not 10 or 11). Otherwise it is 0.
- R6: With `par_mode` LOW (00), `par_err` stays 0 whatever the data and parity bit are.
- R7: With `par_mode` MID (01) and the encoder enabled, only the eight data bits and `par_in` are covered, and the control bits do not affect `par_err`.
- R8: With `par_mode` HIGH, or with `par_mode` MID and the encoder bypassed, the data bits, both control bits and `par_in` are all covered.
- R9: Parity is odd: `par_err` is 1 when the covered bits contain an even number of ones, and 0 when the number is odd.
- R10: `par_err` is registered and is valid in the same cycle as the character it refers to, and back-to-back characters each carry their own flag.
- R11: While `rst_n` is low at a rising edge, all outputs are cleared to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Character data bits |
| ctrl_in | input | 2 | Character control bits |
| sel_in | input | 1 | Special-character select |
| par_in | input | 1 | Odd-parity bit |
| xmode_enc | input | 2 | Three-level code; LOW bypasses the encoder |
| xmode_sel | input | 2 | Three-level code; HIGH suppresses the select bit |
| par_mode | input | 2 | Three-level parity control |
| raw_char | output | 10 | Pre-encoded character (bypass mode) |
| enc_data | output | 8 | Data for the encoder |
| enc_ctrl | output | 2 | Control for the encoder |
| enc_sel | output | 1 | Select for the encoder |
| enc_active | output | 1 | Captured encoder-enable state |
| par_err | output | 1 | Odd-parity failure for the presented character |

## Verification
Every result, including the routed fields, `enc_active` and `par_err`, is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each sample lands half a cycle after the capturing edge and before any new input is sampled. The vector walk applies a new character on every cycle, so it also shows that each flag stays with its own character. Reset is checked one edge after `rst_n` falls, with nonzero inputs held on the pins.

// File: rtl/tcp_pkg.sv
// Package: shared codes for the transmit capture block.
// Assumes three-level pins arrive as 2-bit codes; 11 is read as HIGH.
package tcp_pkg;
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_HIX  = 2'b11
    } lvl_code_t;

    typedef enum logic [1:0] {
        COV_NONE = 2'b00,
        COV_DATA = 2'b01,
        COV_FULL = 2'b10
    } cov_t;
endpackage

// File: rtl/tcp_mode_ctl.sv
// Module: decodes the three-level configuration codes into the encoder
// enable, the select-pass gate and the parity coverage class.
// Assumes codes are stable for the cycle in which they are sampled.
module tcp_mode_ctl
    import tcp_pkg::*;
(
    input  logic [1:0] xmode_enc,
    input  logic [1:0] xmode_sel,
    input  logic [1:0] par_mode,
    output logic       enc_on,
    output logic       sel_ok,
    output cov_t       cov
);
    logic pm_low;
    logic pm_mid;

    // Encoder enable and select gate from the mode codes.
    always_comb begin
        enc_on = (lvl_code_t'(xmode_enc) != LVL_LOW);
        sel_ok = enc_on && (lvl_code_t'(xmode_sel) != LVL_HIGH)
                        && (lvl_code_t'(xmode_sel) != LVL_HIX);
    end

    // Coverage class from parity control and encoder state.
    always_comb begin
        pm_low = (lvl_code_t'(par_mode) == LVL_LOW);
        pm_mid = (lvl_code_t'(par_mode) == LVL_MID);
        if (pm_low)
            cov = COV_NONE;
        else if (pm_mid && enc_on)
            cov = COV_DATA;
        else
            cov = COV_FULL;
    end
endmodule

// File: rtl/tcp_parity.sv
// Module: odd-parity test over a selectable set of character bits.
// Assumes the coverage class is already decoded; output is combinational.
module tcp_parity
    import tcp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              par_bit,
    input  cov_t              cov,
    output logic              bad
);
    logic data_x;
    logic ctrl_x;

    // Reduce each field and flag an even total of ones.
    always_comb begin
        data_x = ^data;
        ctrl_x = ^ctrl;
        unique case (cov)
            COV_DATA: bad = ~(data_x ^ par_bit);
            COV_FULL: bad = ~(data_x ^ ctrl_x ^ par_bit);
            default:  bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcp_route.sv
// Module: steers captured bits to the bypass word or the encoder fields.
// Assumes unused fields must read as zero.
module tcp_route #(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 2,
    localparam int RAW_W = DATA_W + CTRL_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              sel,
    input  logic              enc_on,
    input  logic              sel_ok,
    output logic [RAW_W-1:0]  raw,
    output logic [DATA_W-1:0] e_data,
    output logic [CTRL_W-1:0] e_ctrl,
    output logic              e_sel
);
    // Bypass word: data in the low bits, control bits above them.
    genvar gi;
    generate
        for (gi = 0; gi < RAW_W; gi++) begin : g_raw
            if (gi < DATA_W) begin : g_d
                assign raw[gi] = data[gi] & ~enc_on;
            end else begin : g_c
                assign raw[gi] = ctrl[gi-DATA_W] & ~enc_on;
            end
        end
    endgenerate

    // Encoder-side fields, zero while bypassed.
    always_comb begin
        e_data = enc_on ? data : '0;
        e_ctrl = enc_on ? ctrl : '0;
        e_sel  = sel_ok & sel;
    end
endmodule

// File: rtl/tx_char_capture.sv
// Module: one-cycle capture register for a transmit character with mode
// routing and an odd-parity flag aligned to the registered character.
// Assumes a single clock and synchronous active-low reset.
module tx_char_capture
    import tcp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 2,
    localparam int RAW_W = DATA_W + CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              sel_in,
    input  logic              par_in,
    input  logic [1:0]        xmode_enc,
    input  logic [1:0]        xmode_sel,
    input  logic [1:0]        par_mode,
    output logic [RAW_W-1:0]  raw_char,
    output logic [DATA_W-1:0] enc_data,
    output logic [CTRL_W-1:0] enc_ctrl,
    output logic              enc_sel,
    output logic              enc_active,
    output logic              par_err
);
    logic              enc_on;
    logic              sel_ok;
    cov_t              cov;
    logic              bad_n;
    logic [RAW_W-1:0]  raw_n;
    logic [DATA_W-1:0] ed_n;
    logic [CTRL_W-1:0] ec_n;
    logic              es_n;

    tcp_mode_ctl u_mode (
        .xmode_enc (xmode_enc),
        .xmode_sel (xmode_sel),
        .par_mode  (par_mode),
        .enc_on    (enc_on),
        .sel_ok    (sel_ok),
        .cov       (cov)
    );

    tcp_parity #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_par (
        .data    (data_in),
        .ctrl    (ctrl_in),
        .par_bit (par_in),
        .cov     (cov),
        .bad     (bad_n)
    );

    tcp_route #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_route (
        .data   (data_in),
        .ctrl   (ctrl_in),
        .sel    (sel_in),
        .enc_on (enc_on),
        .sel_ok (sel_ok),
        .raw    (raw_n),
        .e_data (ed_n),
        .e_ctrl (ec_n),
        .e_sel  (es_n)
    );

    // Capture register: routed fields and parity flag move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_char   <= '0;
            enc_data   <= '0;
            enc_ctrl   <= '0;
            enc_sel    <= 1'b0;
            enc_active <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            raw_char   <= raw_n;
            enc_data   <= ed_n;
            enc_ctrl   <= ec_n;
            enc_sel    <= es_n;
            enc_active <= enc_on;
            par_err    <= bad_n;
        end
    end

    // R3: bypass word follows the previous cycle's data and control pins.
    a_r3_raw_map: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !enc_active) |-> (raw_char == $past({ctrl_in, data_in})));

    // R4: encoder-side data follows the pins, and the bypass word is quiet.
    a_r4_enc_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && enc_active) |-> (enc_data == $past(data_in) && raw_char == '0));

    // R5: a HIGH select-mode code blocks the select bit.
    a_r5_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(xmode_sel[1])) |-> !enc_sel);

    // R6: parity control LOW never raises an error.
    a_r6_no_err_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(par_mode) == 2'b00) |-> !par_err);

    // R11: the first cycle after reset shows cleared outputs.
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (raw_char == '0 && !par_err && !enc_active && !enc_sel));
endmodule

// File: tb/sim_tx_char_capture.sv
module sim_tx_char_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic [1:0] ctrl_in = '0;
    logic       sel_in = 1'b0;
    logic       par_in = 1'b0;
    logic [1:0] xmode_enc = '0;
    logic [1:0] xmode_sel = '0;
    logic [1:0] par_mode = '0;
    logic [9:0] raw_char;
    logic [7:0] enc_data;
    logic [1:0] enc_ctrl;
    logic       enc_sel;
    logic       enc_active;
    logic       par_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_char_capture u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .ctrl_in(ctrl_in),
        .sel_in(sel_in), .par_in(par_in), .xmode_enc(xmode_enc),
        .xmode_sel(xmode_sel), .par_mode(par_mode), .raw_char(raw_char),
        .enc_data(enc_data), .enc_ctrl(enc_ctrl), .enc_sel(enc_sel),
        .enc_active(enc_active), .par_err(par_err)
    );

    // Fields: [18:17] enc mode, [16:15] sel mode, [14:13] parity ctl,
    // [12] sel, [11] parity bit, [10:9] ctrl, [8:1] data, [0] expected error.
    localparam logic [18:0] VECS [13] = '{
        {2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 8'h00, 1'b0}, // R6 bypass, off
        {2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 2'b01, 8'h00, 1'b0}, // R8 MID bypass odd
        {2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 2'b01, 8'h01, 1'b1}, // R8 MID bypass even
        {2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 2'b11, 8'h07, 1'b0}, // R7 ctrl ignored
        {2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 2'b01, 8'h03, 1'b1}, // R7 data-only even
        {2'b10, 2'b01, 2'b10, 1'b1, 1'b0, 2'b01, 8'h03, 1'b0}, // R8 HIGH enc odd
        {2'b10, 2'b10, 2'b10, 1'b1, 1'b1, 2'b00, 8'h03, 1'b0}, // R5 sel blocked
        {2'b01, 2'b10, 2'b10, 1'b1, 1'b1, 2'b01, 8'h03, 1'b1}, // R9 even count
        {2'b00, 2'b10, 2'b10, 1'b0, 1'b1, 2'b11, 8'hFF, 1'b0}, // R8 HIGH bypass odd
        {2'b00, 2'b10, 2'b10, 1'b0, 1'b0, 2'b11, 8'hFF, 1'b1}, // R8 HIGH bypass even
        {2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0}, // R6 enc, off
        {2'b01, 2'b00, 2'b01, 1'b0, 1'b1, 2'b10, 8'hA5, 1'b0}, // R7 odd
        {2'b11, 2'b00, 2'b11, 1'b0, 1'b0, 2'b10, 8'h01, 1'b1}  // R2 code 11 as HIGH
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [18:0] v);
        xmode_enc = v[18:17];
        xmode_sel = v[16:15];
        par_mode  = v[14:13];
        sel_in    = v[12];
        par_in    = v[11];
        ctrl_in   = v[10:9];
        data_in   = v[8:1];
    endtask

    // Expected fields computed from R2..R5 for the vector last applied.
    task automatic check_vec(input logic [18:0] v, input string tag);
        logic on;
        logic selp;
        on   = (v[18:17] != 2'b00);
        selp = on && !v[16] && v[12];
        check({"R2 enc_active ", tag}, {9'b0, enc_active}, {9'b0, on});
        check({"R3 raw_char ", tag}, raw_char, on ? 10'h000 : {v[10:9], v[8:1]});
        check({"R4 enc_data/ctrl ", tag}, {enc_ctrl, enc_data},
              on ? {v[10:9], v[8:1]} : 10'h000);
        check({"R5 enc_sel ", tag}, {9'b0, enc_sel}, {9'b0, selp});
        check({"R9 par_err ", tag}, {9'b0, par_err}, {9'b0, v[0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset with busy inputs keeps outputs clear.
        apply(VECS[9]);
        repeat (3) @(negedge clk);
        check("R11 reset raw", raw_char, 10'h000);
        check("R11 reset flags", {6'b0, enc_sel, enc_active, par_err, 1'b0}, 10'h000);
        rst_n = 1'b1;

        // R1 R10: one vector per cycle, outputs read a cycle later.
        for (int i = 0; i < 13; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i], $sformatf("R1 R10 vec%0d", i));
        end

        // R10: alternating error and clean characters back to back.
        for (int k = 0; k < 4; k++) begin
            apply((k % 2 == 0) ? VECS[4] : VECS[3]);
            @(negedge clk);
            check("R10 alternating", {9'b0, par_err}, {9'b0, (k % 2 == 0)});
        end

        // R7: MID with encoder on, toggle only ctrl; flag unchanged.
        apply({2'b01, 2'b00, 2'b01, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0});
        @(negedge clk);
        check("R7 ctrl 00", {9'b0, par_err}, 10'h000);
        ctrl_in = 2'b01;
        @(negedge clk);
        check("R7 ctrl 01", {9'b0, par_err}, 10'h000);

        // R6: LOW parity control with even count everywhere.
        apply({2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 2'b11, 8'h0F, 1'b0});
        @(negedge clk);
        check("R6 low even", {9'b0, par_err}, 10'h000);

        // R11: reset in mid-stream clears a standing error.
        apply(VECS[9]);
        @(negedge clk);
        check("R11 pre-reset err", {9'b0, par_err}, 10'h001);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset raw", raw_char, 10'h000);
        check("R11 mid reset err", {9'b0, par_err}, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", raw_char, {2'b11, 8'hFF});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule